// File: doc/BRIEF.md
# Bus-Conflict Instruction Cache

This block sits in an instruction sequencer and keeps a small, fully associative set of instructions. It records only those instructions whose fetch ran into a data transfer on the shared program-memory bus. When the same fetch meets such a collision again, the instruction comes from the cache in the same cycle. The data transfer keeps the bus and the pipeline does not stall.

A colliding fetch that misses costs exactly one stall cycle. In that stall cycle the data transfer uses the bus. In the following cycle the instruction word arrives from memory, is passed straight to the output and is written into the cache. The written entry is a free entry if one exists, otherwise the least recently used one. Fetches that meet no collision always take their word from memory and never fill the cache. No setup is needed after reset: the cache is empty and active. A freeze input holds the contents and the replacement order unchanged. A flush input drops every entry in one cycle.

Top module: `pm_conflict_cache`

## Requirements
- R1: After reset, stall is 0, the cache holds no entries and allocation is active without any setup, so the first colliding fetch of any address misses and is then stored.
- R2: A colliding fetch (fetch_valid=1, bus_conflict=1) that misses drives stall=1 in that cycle. In the next cycle stall=0, instr_out equals mem_instr, and that word is stored under the captured address.
- R3: A miss stalls for exactly one cycle. fetch_valid, bus_conflict and fetch_addr are ignored in the fill cycle that follows the stall.
- R4: A colliding fetch that hits drives stall=0 and puts the stored word on instr_out in the same cycle, whatever mem_instr carries.
- R5: A fetch without a collision drives instr_out=mem_instr and stall=0 and stores nothing, so a later colliding fetch of that address misses. The same holds when fetch_valid is 0.
- R6: The cache holds 32 entries and any 32 distinct addresses can be resident at once. The tag is the full 24-bit fetch address.
- R7: When all entries are valid, a fill replaces the least recently used entry. Both a served hit and a fill count as a use.
- R8: While freeze=1 in the fill cycle, nothing is stored. While freeze=1 on a hit, the hit is served but the replacement order is not changed. A miss still costs one stall cycle.
- R9: flush=1 invalidates every entry from the next cycle on. A flush in the fill cycle stops that word from being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction fetch is requested this cycle |
| fetch_addr | input | 24 | Fetch address, also the tag |
| bus_conflict | input | 1 | A data transfer wants the program-memory bus this cycle |
| mem_instr | input | 48 | Instruction word from memory |
| freeze | input | 1 | Hold contents and replacement order |
| flush | input | 1 | Invalidate all entries |
| instr_out | output | 48 | Instruction delivered to the sequencer |
| stall | output | 1 | Sequencer must hold this cycle |

## Verification
The fill write and a flush can fall in the same cycle. The fill cycle of a miss and a new colliding fetch can also coincide, and that fetch must be ignored. The bench raises flush during the fill cycle and then looks for a second miss on the same address. It drives a conflicting fetch during a fill and checks that stall stays low and that mem_instr is passed through. Freeze is applied during the fill cycle and judged the same way, by the next colliding fetch of that address missing. Eviction order is judged by which addresses still hit once a full cache has been refreshed at one entry and then overflowed.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int PCC_ENTRIES = 32;
    localparam int PCC_TAG_W   = 24;
    localparam int PCC_INSTR_W = 48;

    typedef enum logic {
        PCC_IDLE = 1'b0,
        PCC_FILL = 1'b1
    } pcc_state_e;

    function automatic int pcc_idx_w(input int entries);
        return (entries > 1) ? $clog2(entries) : 1;
    endfunction

endpackage

// File: rtl/pcc_store.sv
module pcc_store #(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 24,
    parameter int INSTR_W = 48,
    parameter int IDX_W   = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                wr_tag,
    input  logic [INSTR_W-1:0]              wr_data,
    input  logic                            flush,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [ENTRIES-1:0]              valid_o,
    output logic [ENTRIES-1:0][TAG_W-1:0]   tags_o,
    output logic [INSTR_W-1:0]              rd_data
);

    logic [ENTRIES-1:0]               valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0]    tag_q;
    logic [ENTRIES-1:0][INSTR_W-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign valid_o = valid_q;
    assign tags_o  = tag_q;
    assign rd_data = data_q[rd_idx];

    // R9: a flush empties the cache by the next cycle
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_o == '0));

    // R2: a fill leaves its entry valid
    p_fill_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_o[$past(wr_idx)]);

endmodule

// File: rtl/pcc_lookup.sv
module pcc_lookup #(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 24,
    parameter int IDX_W   = 5
) (
    input  logic [TAG_W-1:0]               addr,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  tags,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           free_any,
    output logic [IDX_W-1:0]               free_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == addr);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pcc_lru.sv
module pcc_lru #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);

    localparam logic [IDX_W-1:0] AGE_TOP = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [ENTRIES-1:0]            oldest_vec;
    logic [IDX_W-1:0]              ref_age;

    assign ref_age = age_q[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[g] <= IDX_W'(g);
            end else if (touch) begin
                if (touch_idx == IDX_W'(g))
                    age_q[g] <= '0;
                else if (age_q[g] < ref_age)
                    age_q[g] <= age_q[g] + 1'b1;
            end
        end
        assign oldest_vec[g] = (age_q[g] == AGE_TOP);
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oldest_vec[i]) oldest_idx = IDX_W'(i);
        end
    end

    // R7: the ages stay a permutation, so exactly one entry is oldest
    p_one_oldest_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);

endmodule

// File: rtl/pm_conflict_cache.sv
module pm_conflict_cache
    import pcc_pkg::*;
#(
    parameter int ENTRIES = PCC_ENTRIES,
    parameter int TAG_W   = PCC_TAG_W,
    parameter int INSTR_W = PCC_INSTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_valid,
    input  logic [TAG_W-1:0]   fetch_addr,
    input  logic               bus_conflict,
    input  logic [INSTR_W-1:0] mem_instr,
    input  logic               freeze,
    input  logic               flush,
    output logic [INSTR_W-1:0] instr_out,
    output logic               stall
);

    localparam int IDX_W = pcc_idx_w(ENTRIES);

    pcc_state_e                     state_q;
    logic [TAG_W-1:0]               fill_tag_q;
    logic [IDX_W-1:0]               fill_idx_q;

    logic [ENTRIES-1:0]             valid;
    logic [ENTRIES-1:0][TAG_W-1:0]  tags;
    logic [ENTRIES-1:0]             hit_vec;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;
    logic                           free_any;
    logic [IDX_W-1:0]               free_idx;
    logic [IDX_W-1:0]               oldest_idx;
    logic [IDX_W-1:0]               victim_idx;
    logic [INSTR_W-1:0]             rd_data;

    logic                           collide;
    logic                           hit_serve;
    logic                           miss;
    logic                           wr_en;
    logic                           touch;
    logic [IDX_W-1:0]               touch_idx;

    assign collide   = (state_q == PCC_IDLE) && fetch_valid && bus_conflict;
    assign hit_serve = collide && hit;
    assign miss      = collide && !hit;
    assign wr_en     = (state_q == PCC_FILL) && !freeze;
    assign touch     = (hit_serve && !freeze) || wr_en;
    assign touch_idx = wr_en ? fill_idx_q : hit_idx;
    assign victim_idx = free_any ? free_idx : oldest_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PCC_IDLE;
            fill_tag_q <= '0;
            fill_idx_q <= '0;
        end else begin
            case (state_q)
                PCC_IDLE: if (miss) begin
                    state_q    <= PCC_FILL;
                    fill_tag_q <= fetch_addr;
                    fill_idx_q <= victim_idx;
                end
                PCC_FILL: state_q <= PCC_IDLE;
                default:  state_q <= PCC_IDLE;
            endcase
        end
    end

    pcc_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (fill_idx_q),
        .wr_tag  (fill_tag_q),
        .wr_data (mem_instr),
        .flush   (flush),
        .rd_idx  (hit_idx),
        .valid_o (valid),
        .tags_o  (tags),
        .rd_data (rd_data)
    );

    pcc_lookup #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .IDX_W   (IDX_W)
    ) i_lookup (
        .addr     (fetch_addr),
        .valid    (valid),
        .tags     (tags),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    pcc_lru #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) i_lru (
        .clk        (clk),
        .rst        (rst),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .oldest_idx (oldest_idx)
    );

    assign instr_out = hit_serve ? rd_data : mem_instr;
    assign stall     = miss;

    // R3: a miss never stalls two cycles in a row
    p_single_stall_r3: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R2: the cycle after a stall delivers the memory word
    p_fill_pass_r2: assert property (@(posedge clk) disable iff (rst)
        stall |=> (instr_out == mem_instr));

    // R6: an address is resident in at most one entry
    p_unique_tag_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: tb/test_pm_conflict_cache.sv
module test_pm_conflict_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        bus_conflict = 1'b0;
    logic [47:0] mem_instr = '0;
    logic        freeze = 1'b0;
    logic        flush = 1'b0;
    logic [47:0] instr_out;
    logic        stall;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [47:0] GARB = 48'hBAD0BAD0BAD0;
    localparam logic [47:0] MEMW = 48'h0123456789AB;
    localparam logic [47:0] D100 = 48'h000100FFFEFF;
    localparam logic [47:0] D200 = 48'h000200FFFDFF;
    localparam logic [47:0] D300 = 48'h000300FFFCFF;

    typedef struct packed {
        logic        fv;
        logic        cf;
        logic        frz;
        logic        fl;
        logic [23:0] addr;
        logic [47:0] mem;
        logic        est;
        logic [47:0] ein;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,24'h000000,MEMW,1'b0,MEMW,4'd1}, // R1 idle after reset
        '{1'b1,1'b1,1'b0,1'b0,24'h000100,GARB,1'b1,GARB,4'd2}, // R2 miss stalls
        '{1'b1,1'b1,1'b0,1'b0,24'h000777,D100,1'b0,D100,4'd3}, // R3 fill ignores fetch
        '{1'b1,1'b1,1'b0,1'b0,24'h000100,GARB,1'b0,D100,4'd4}, // R4 hit
        '{1'b1,1'b0,1'b0,1'b0,24'h000200,D200,1'b0,D200,4'd5}, // R5 plain fetch
        '{1'b1,1'b1,1'b0,1'b0,24'h000200,GARB,1'b1,GARB,4'd5}, // R5 not allocated
        '{1'b0,1'b0,1'b0,1'b0,24'h000000,D200,1'b0,D200,4'd2}, // R2 fill
        '{1'b1,1'b1,1'b0,1'b0,24'h000200,GARB,1'b0,D200,4'd4}, // R4 hit
        '{1'b1,1'b1,1'b1,1'b0,24'h000300,GARB,1'b1,GARB,4'd8}, // R8 miss under freeze
        '{1'b0,1'b0,1'b1,1'b0,24'h000000,D300,1'b0,D300,4'd8}, // R8 fill frozen
        '{1'b1,1'b1,1'b0,1'b0,24'h000300,GARB,1'b1,GARB,4'd8}, // R8 nothing stored
        '{1'b0,1'b0,1'b0,1'b0,24'h000000,D300,1'b0,D300,4'd2}, // R2 fill
        '{1'b1,1'b1,1'b1,1'b0,24'h000100,GARB,1'b0,D100,4'd8}, // R8 hit while frozen
        '{1'b0,1'b0,1'b0,1'b1,24'h000000,MEMW,1'b0,MEMW,4'd9}, // R9 flush
        '{1'b1,1'b1,1'b0,1'b0,24'h000100,GARB,1'b1,GARB,4'd9}, // R9 flushed -> miss
        '{1'b0,1'b0,1'b0,1'b1,24'h000000,D100,1'b0,D100,4'd9}, // R9 flush in fill
        '{1'b1,1'b1,1'b0,1'b0,24'h000100,GARB,1'b1,GARB,4'd9}, // R9 fill dropped
        '{1'b0,1'b0,1'b0,1'b0,24'h000000,D100,1'b0,D100,4'd2}, // R2 fill
        '{1'b1,1'b1,1'b0,1'b0,24'h000100,GARB,1'b0,D100,4'd4}  // R4 hit again
    };

    pm_conflict_cache i_pm_conflict_cache (
        .clk          (clk),
        .rst          (rst),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .bus_conflict (bus_conflict),
        .mem_instr    (mem_instr),
        .freeze       (freeze),
        .flush        (flush),
        .instr_out    (instr_out),
        .stall        (stall)
    );

    always #4 clk = ~clk;

    function automatic logic [47:0] dval(input logic [23:0] a);
        return {a, ~a};
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic fv, input logic cf, input logic [23:0] a,
                         input logic [47:0] m, input logic frz, input logic fl);
        @(negedge clk);
        fetch_valid = fv; bus_conflict = cf; fetch_addr = a;
        mem_instr = m; freeze = frz; flush = fl;
        #2;
    endtask

    task automatic do_miss(input string req, input logic [23:0] a, input logic frz);
        drive(1'b1, 1'b1, a, GARB, frz, 1'b0);
        check(req, {47'd0, stall}, 48'd1);
        drive(1'b0, 1'b0, 24'h0, dval(a), frz, 1'b0);
        check(req, {47'd0, stall}, 48'd0);
        check(req, instr_out, dval(a));
    endtask

    task automatic do_hit(input string req, input logic [23:0] a);
        drive(1'b1, 1'b1, a, GARB, 1'b0, 1'b0);
        check(req, {47'd0, stall}, 48'd0);
        check(req, instr_out, dval(a));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            drive(VECS[k].fv, VECS[k].cf, VECS[k].addr, VECS[k].mem,
                  VECS[k].frz, VECS[k].fl);
            check($sformatf("R%0d row %0d stall", VECS[k].req, k),
                  {47'd0, stall}, {47'd0, VECS[k].est});
            check($sformatf("R%0d row %0d instr", VECS[k].req, k),
                  instr_out, VECS[k].ein);
        end

        // R1: reset mid-run clears the contents
        drive(1'b0, 1'b0, 24'h0, MEMW, 1'b0, 1'b0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 stall after reset", {47'd0, stall}, 48'd0);
        do_miss("R1 empty after reset", 24'h000100, 1'b0);

        // R6: fill the remaining 31 entries, then every one hits
        for (int i = 1; i < 32; i++) do_miss("R6 fill", 24'h001000 + 24'(i), 1'b0);
        do_hit("R6 resident", 24'h000100);
        for (int i = 1; i < 32; i++) do_hit("R6 resident", 24'h001000 + 24'(i));

        // R7: refresh the oldest, overflow, check eviction order
        do_hit("R7 refresh", 24'h000100);
        do_miss("R7 overflow", 24'h002000, 1'b0);
        do_miss("R7 lru evicted", 24'h001001, 1'b0);
        do_hit("R7 kept", 24'h001003);
        do_hit("R7 refreshed kept", 24'h000100);
        do_hit("R7 new kept", 24'h002000);
        do_miss("R7 second victim", 24'h001002, 1'b1);
        do_miss("R8 frozen no store", 24'h001002, 1'b1);
        do_hit("R7 others intact", 24'h001004);

        drive(1'b0, 1'b0, 24'h0, MEMW, 1'b0, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule